// File: doc/BRIEF.md
# Sequential Buffer Host Register Port

This block sits between an 8-bit host bus and the 2048-byte single-port buffer RAM of a network controller. The host never addresses the RAM directly. It loads an 11-bit pointer through two pointer registers, then moves bytes one at a time through a single data-port register. A mode bit in the upper pointer register turns on auto-increment. A direction bit prepares the block for reads. In read mode the addressed byte is fetched ahead of time into a data latch, so a data-port read returns at once.

The same block holds five ID and setup bytes that all share one register offset. A 3-bit selector chooses which byte appears there. The two low selector bits are the same storage as the two low bits of the configuration register. The top selector bit lives in a separate sub-address register and is cleared by every configuration-register write.

Host register offsets: 0 configuration, 1 data port, 2 pointer high, 3 pointer low, 4 sub-address, 7 selected ID/setup byte; offsets 5 and 6 read as zero.

Top module: `hsb_host_port`

## Requirements
- R1: After reset the pointer (offsets 2 and 3), the sub-address (offset 4), the configuration byte (offset 0) and all five selectable bytes read as 0x00.
- R2: The 11-bit RAM pointer takes bits 10..8 from offset 2 bits 2..0 and bits 7..0 from offset 3, and both read back the stored value.
- R3: Offset 2 bit 7 is the direction (1 = read) and bit 6 is auto-increment; both read back. Bits 5..3 always read 0 and writes to them are dropped.
- R4: A write to offset 1 stores the byte into RAM at the current pointer in the same cycle.
- R5: With direction = read, a write to offset 3 prefetches the byte at the new pointer, and a read of offset 1 at least two idle cycles later returns that byte.
- R6: With auto-increment = 1 each offset-1 access advances the pointer by one, wrapping from 0x7FF to 0x000. With auto-increment = 0 the pointer holds.
- R7: In read mode each offset-1 read refetches the latch from the pointer as updated by that access. Spaced reads with auto-increment return consecutive bytes, including across the wrap.
- R8: Offset 4 holds the 3-bit selector in bits 2..0, and bits 7..3 read 0. Offset 7 reaches selector 0 tentative ID, 1 node ID, 2 setup 1, 3 next ID and 4 setup 2, each writable and readable.
- R9: Selector values 5, 6 and 7 read 0 at offset 7, and writes there change none of the five bytes.
- R10: Offset 0 bits 1..0 and offset 4 bits 1..0 are one storage. A write to offset 0 also clears selector bit 2. Offset 0 bits 7..2 read back as written.
- R11: A data-port write in the cycle a prefetch would use the RAM takes the port. The prefetch runs on the next free cycle, so the latch holds the byte as it stands after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 8 | Read data for the offset on host_addr |
| ram_addr | output | 11 | Buffer RAM address |
| ram_wdata | output | 8 | Buffer RAM write data |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_re | output | 1 | Buffer RAM read enable, data back one cycle later |
| ram_rdata | input | 8 | Buffer RAM read data |

## Verification
The RAM can be claimed twice in one cycle: a host data-port write and the prefetch left pending by a pointer-low write in read mode. The bench provokes this by writing pointer-low and then the data port on the very next cycle. It then checks two things. The written byte must land in the RAM model, and the following data-port read must return that new byte rather than the stale contents. This is run with auto-increment off, and with it on, where the fetch must move to the next address.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    localparam int BYTE_W  = 8;
    localparam int SUB_W   = 3;
    localparam int NUM_SEL = 5;

    typedef logic [2:0] reg_off_t;

    localparam reg_off_t OFF_CFG  = 3'd0;
    localparam reg_off_t OFF_DATA = 3'd1;
    localparam reg_off_t OFF_PHI  = 3'd2;
    localparam reg_off_t OFF_PLO  = 3'd3;
    localparam reg_off_t OFF_SUB  = 3'd4;
    localparam reg_off_t OFF_SEL  = 3'd7;

    typedef struct packed {
        logic rd_dir;
        logic auto_inc;
    } ptr_mode_t;

    typedef struct packed {
        logic wr_cfg;
        logic wr_phi;
        logic wr_plo;
        logic wr_sub;
        logic wr_sel;
        logic dp_wr;
        logic dp_rd;
    } host_stb_t;

    function automatic host_stb_t decode_host(input reg_off_t off, input logic wr, input logic rd);
        host_stb_t s;
        s.wr_cfg = wr && (off == OFF_CFG);
        s.wr_phi = wr && (off == OFF_PHI);
        s.wr_plo = wr && (off == OFF_PLO);
        s.wr_sub = wr && (off == OFF_SUB);
        s.wr_sel = wr && (off == OFF_SEL);
        s.dp_wr  = wr && (off == OFF_DATA);
        s.dp_rd  = rd && !wr && (off == OFF_DATA);
        return s;
    endfunction

endpackage

// File: rtl/hsb_ptr.sv
module hsb_ptr
    import hsb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  host_stb_t           stb,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   ptr_q,
    output ptr_mode_t           mode_q,
    output logic [BYTE_W-1:0]   latch_q,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [BYTE_W-1:0]   ram_wdata,
    output logic                ram_we,
    output logic                ram_re,
    input  logic [BYTE_W-1:0]   ram_rdata
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic fetch_pend;
    logic fetch_busy;
    logic dp_access;
    logic want_fetch;

    assign dp_access  = stb.dp_wr || stb.dp_rd;
    assign want_fetch = mode_q.rd_dir && (stb.wr_plo || stb.dp_rd);

    // The host write always owns the port; a pending fetch waits a cycle.
    assign ram_we    = stb.dp_wr;
    assign ram_re    = fetch_pend && !stb.dp_wr;
    assign ram_addr  = ptr_q;
    assign ram_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            mode_q     <= '0;
            latch_q    <= '0;
            fetch_pend <= 1'b0;
            fetch_busy <= 1'b0;
        end else begin
            if (stb.wr_phi) begin
                mode_q.rd_dir          <= wdata[7];
                mode_q.auto_inc        <= wdata[6];
                ptr_q[ADDR_W-1:BYTE_W] <= wdata[HI_W-1:0];
            end
            if (stb.wr_plo)
                ptr_q[BYTE_W-1:0] <= wdata;
            if (dp_access && mode_q.auto_inc)
                ptr_q <= ptr_q + ADDR_W'(1);
            if (want_fetch)
                fetch_pend <= 1'b1;
            else if (ram_re)
                fetch_pend <= 1'b0;
            fetch_busy <= ram_re;
            if (fetch_busy)
                latch_q <= ram_rdata;
        end
    end

    // R11: RAM port never driven for read and write together
    p_port_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(ram_we && ram_re));

    // R11: a fetch blocked by a host write is still owed on the next cycle
    p_fetch_deferred_r11: assert property (@(posedge clk) disable iff (rst)
        (fetch_pend && stb.dp_wr) |=> fetch_pend);

    // R6: auto-increment advances by exactly one, wrapping at the top
    p_ptr_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (dp_access && mode_q.auto_inc) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

    // R6: without auto-increment or pointer writes the pointer is stable
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.auto_inc && !stb.wr_phi && !stb.wr_plo) |=> $stable(ptr_q));

    // R5: pointer-low write in read mode leaves a fetch owed
    p_prefetch_r5: assert property (@(posedge clk) disable iff (rst)
        (stb.wr_plo && mode_q.rd_dir) |=> fetch_pend);

endmodule

// File: rtl/hsb_idbank.sv
module hsb_idbank
    import hsb_pkg::*;
#(
    parameter int NUM = NUM_SEL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SUB_W-1:0]   sel,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  rdata
);
    logic [NUM-1:0][BYTE_W-1:0] bank_q;

    for (genvar g = 0; g < NUM; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[g] <= '0;
            else if (wr_en && (sel == SUB_W'(g)))
                bank_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM; i++)
            if (sel == SUB_W'(i))
                rdata = bank_q[i];
    end

    // R9: writes at reserved selector values leave every byte untouched
    p_reserved_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel >= SUB_W'(NUM))) |=> $stable(bank_q));

    // R9: reserved selector values read zero
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (sel >= SUB_W'(NUM)) |-> (rdata == '0));

endmodule

// File: rtl/hsb_host_port.sv
module hsb_host_port
    import hsb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [7:0]         host_rdata,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic [7:0]         ram_wdata,
    output logic               ram_we,
    output logic               ram_re,
    input  logic [7:0]         ram_rdata
);
    localparam int HI_W = ADDR_W - BYTE_W;

    host_stb_t             stb;
    logic [ADDR_W-1:0]     ptr;
    ptr_mode_t             mode;
    logic [BYTE_W-1:0]     latch;
    logic [BYTE_W-1:0]     sel_rdata;
    logic [SUB_W-1:0]      sub_q;
    logic [BYTE_W-3:0]     cfg_hi_q;

    assign stb = decode_host(host_addr, host_wr, host_rd);

    hsb_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .stb       (stb),
        .wdata     (host_wdata),
        .ptr_q     (ptr),
        .mode_q    (mode),
        .latch_q   (latch),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_rdata (ram_rdata)
    );

    hsb_idbank #(.NUM(NUM_SEL)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (stb.wr_sel),
        .sel   (sub_q),
        .wdata (host_wdata),
        .rdata (sel_rdata)
    );

    // Selector: low bits shared with the configuration byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q    <= '0;
            cfg_hi_q <= '0;
        end else if (stb.wr_cfg) begin
            cfg_hi_q   <= host_wdata[7:2];
            sub_q[1:0] <= host_wdata[1:0];
            sub_q[2]   <= 1'b0;
        end else if (stb.wr_sub) begin
            sub_q <= host_wdata[SUB_W-1:0];
        end
    end

    always_comb begin
        unique case (host_addr)
            OFF_CFG:  host_rdata = {cfg_hi_q, sub_q[1:0]};
            OFF_DATA: host_rdata = latch;
            OFF_PHI:  host_rdata = {mode.rd_dir, mode.auto_inc, {(6-HI_W){1'b0}}, ptr[ADDR_W-1:BYTE_W]};
            OFF_PLO:  host_rdata = ptr[BYTE_W-1:0];
            OFF_SUB:  host_rdata = {{(BYTE_W-SUB_W){1'b0}}, sub_q};
            OFF_SEL:  host_rdata = sel_rdata;
            default:  host_rdata = '0;
        endcase
    end

    // R10: a configuration write always leaves selector bit 2 clear
    p_cfg_clears_top_r10: assert property (@(posedge clk) disable iff (rst)
        stb.wr_cfg |=> (sub_q[2] == 1'b0));

    // R10: a configuration write lands its low bits in the selector
    p_cfg_shares_low_r10: assert property (@(posedge clk) disable iff (rst)
        stb.wr_cfg |=> (sub_q[1:0] == $past(host_wdata[1:0])));

    // R3: pointer-high reserved field always reads zero
    p_phi_resv_r3: assert property (@(posedge clk) disable iff (rst)
        (host_addr == OFF_PHI) |-> (host_rdata[5:3] == 3'b000));

endmodule

// File: tb/hsb_host_port_tb.sv
module hsb_host_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  host_addr;
    logic [7:0]  host_wdata;
    logic        host_wr;
    logic        host_rd;
    logic [7:0]  host_rdata;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic        ram_re;
    logic [7:0]  ram_rdata;

    logic [7:0]  mem [2048];

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsb_host_port u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_re(ram_re), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ptr(input logic [10:0] p, input logic rd, input logic inc);
        hwrite(3'd2, {rd, inc, 3'b000, p[10:8]});
        hwrite(3'd3, p[7:0]);
        idle(2);
    endtask

    task automatic dp_read(output logic [7:0] d);
        hread(3'd1, d);
        idle(2);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        hread(3'd2, v); chk("R1 ptr hi", v, 8'h00);
        hread(3'd3, v); chk("R1 ptr lo", v, 8'h00);
        hread(3'd4, v); chk("R1 sub", v, 8'h00);
        hread(3'd0, v); chk("R1 cfg", v, 8'h00);
        for (int i = 0; i < 5; i++) begin
            hwrite(3'd4, 8'(i));
            hread(3'd7, v); chk("R1 sel byte", v, 8'h00);
        end
    endtask

    task automatic t_ptr_regs;
        logic [7:0] v;
        hwrite(3'd2, 8'hFF);
        hread(3'd2, v); chk("R3 ptr hi reserved bits zero", v, 8'hC7);
        hwrite(3'd2, 8'h05);
        hread(3'd2, v); chk("R2 ptr hi value", v, 8'h05);
        hwrite(3'd3, 8'h9A);
        hread(3'd3, v); chk("R2 ptr lo value", v, 8'h9A);
        hwrite(3'd2, 8'h40);
        hread(3'd2, v); chk("R3 auto-inc bit", v, 8'h40);
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        set_ptr(11'h123, 1'b0, 1'b1);
        hwrite(3'd1, 8'hA5);
        hwrite(3'd1, 8'h3C);
        hwrite(3'd1, 8'h96);
        idle(1);
        chk("R4 ram byte 0x123", mem[11'h123], 8'hA5);
        chk("R4 ram byte 0x125", mem[11'h125], 8'h96);
        hread(3'd3, v); chk("R6 ptr advanced", v, 8'h26);
        set_ptr(11'h123, 1'b1, 1'b1);
        dp_read(v); chk("R5 prefetched byte", v, 8'hA5);
        dp_read(v); chk("R7 next byte", v, 8'h3C);
        dp_read(v); chk("R7 third byte", v, 8'h96);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        set_ptr(11'h7FE, 1'b0, 1'b1);
        hwrite(3'd1, 8'h11);
        hwrite(3'd1, 8'h22);
        hread(3'd2, v); chk("R6 wrap hi", v, 8'h40);
        hread(3'd3, v); chk("R6 wrap lo", v, 8'h00);
        mem[0] = 8'h5E;
        set_ptr(11'h7FF, 1'b1, 1'b1);
        dp_read(v); chk("R7 byte at 0x7FF", v, 8'h22);
        dp_read(v); chk("R7 byte after wrap", v, 8'h5E);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        set_ptr(11'h050, 1'b0, 1'b0);
        hwrite(3'd1, 8'h01);
        hwrite(3'd1, 8'h02);
        hread(3'd3, v); chk("R6 hold ptr", v, 8'h50);
        idle(1);
        chk("R6 hold overwrite", mem[11'h050], 8'h02);
        set_ptr(11'h050, 1'b1, 1'b0);
        dp_read(v); chk("R5 hold read 1", v, 8'h02);
        dp_read(v); chk("R6 hold read 2", v, 8'h02);
        hread(3'd3, v); chk("R6 hold after reads", v, 8'h50);
    endtask

    task automatic t_subaddr;
        logic [7:0] v;
        hwrite(3'd4, 8'hFF);
        hread(3'd4, v); chk("R8 sub upper bits zero", v, 8'h07);
        for (int i = 0; i < 5; i++) begin
            hwrite(3'd4, 8'(i));
            hwrite(3'd7, 8'(8'h30 + i));
        end
        for (int i = 0; i < 5; i++) begin
            hwrite(3'd4, 8'(i));
            hread(3'd7, v); chk("R8 selected byte", v, 8'h30 + i);
        end
    endtask

    task automatic t_reserved;
        logic [7:0] v;
        for (int s = 5; s < 8; s++) begin
            hwrite(3'd4, 8'(s));
            hwrite(3'd7, 8'hEE);
            hread(3'd7, v); chk("R9 reserved reads zero", v, 8'h00);
        end
        for (int i = 0; i < 5; i++) begin
            hwrite(3'd4, 8'(i));
            hread(3'd7, v); chk("R9 bytes untouched", v, 8'h30 + i);
        end
    endtask

    task automatic t_config;
        logic [7:0] v;
        hwrite(3'd4, 8'h04);
        hwrite(3'd0, 8'hA9);
        hread(3'd4, v); chk("R10 cfg clears bit2", v, 8'h01);
        hread(3'd0, v); chk("R10 cfg readback", v, 8'hA9);
        hread(3'd7, v); chk("R10 node ID via cfg", v, 8'h31);
        hwrite(3'd4, 8'h06);
        hread(3'd0, v); chk("R10 sub low bits in cfg", v, 8'hAA);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        mem[11'h300] = 8'h5A;
        mem[11'h301] = 8'h6B;
        hwrite(3'd2, 8'h83);
        @(negedge clk);
        host_addr = 3'd3; host_wdata = 8'h00; host_wr = 1'b1;
        @(negedge clk);
        host_addr = 3'd1; host_wdata = 8'hC3;
        @(negedge clk);
        host_wr = 1'b0;
        idle(3);
        chk("R11 write landed", mem[11'h300], 8'hC3);
        dp_read(v); chk("R11 latch sees new byte", v, 8'hC3);
        hwrite(3'd2, 8'hC3);
        @(negedge clk);
        host_addr = 3'd3; host_wdata = 8'h00; host_wr = 1'b1;
        @(negedge clk);
        host_addr = 3'd1; host_wdata = 8'h4D;
        @(negedge clk);
        host_wr = 1'b0;
        idle(3);
        chk("R11 inc write landed", mem[11'h300], 8'h4D);
        dp_read(v); chk("R11 fetch at next address", v, 8'h6B);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        ram_rdata  = 8'h00;
        host_addr  = 3'd0;
        host_wdata = 8'h00;
        host_wr    = 1'b0;
        host_rd    = 1'b0;
        rst        = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset;
        t_ptr_regs;
        t_write_read;
        t_wrap;
        t_hold;
        t_subaddr;
        t_reserved;
        t_config;
        t_collision;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule